// File: doc/BRIEF.md
# Shared-Bus Branch and Condition-Logic Dispatch Gate

This block sits at the end of an instruction dispatch stage. It steers one instruction per cycle onto a single dispatch bus that is shared by two execution units: a branch unit and a condition-register logic unit. Each unit has a small reservation station of two entries. An entry waits in its station until all of its source operands are ready and its unit can take it. The branch unit also requires that the entry is the oldest branch held.

The two stations issue on their own. A branch can leave its station in the same cycle as a condition-logic instruction, and it can leave ahead of an older condition-logic instruction that is still waiting. Branches always leave in age order. Condition-logic entries may overtake one another: the oldest ready entry issues first. Dispatch of both kinds stops while either station is full. An entry that leaves in a cycle frees its slot only from the next cycle. A flush empties both stations.

Top module: `dispatch_gate`

## Requirements
- R1: An offered instruction (`disp_valid`) goes to exactly one station, chosen by `disp_is_cr` (0 = branch station, 1 = condition-logic station). At most one instruction is admitted per cycle.
- R2: `disp_accept` is high exactly when `disp_valid` is high, `flush` is low and neither station holds two entries. A full station of either kind blocks both kinds.
- R3: A station that starts the cycle full refuses dispatch in that cycle, even when one of its entries issues in the same cycle. Dispatch is admitted in the following cycle.
- R4: Each station holds at most two entries. With two waiting branches, a third branch is refused.
- R5: An entry issues only when both of its operand ready bits are set and its unit-ready input is high. The earliest issue is in the cycle after dispatch. A high issue-valid output means the entry leaves the station at the next edge.
- R6: Branches issue strictly in age order. A younger ready branch waits while an older branch is not ready.
- R7: The condition-logic station issues its oldest ready entry. A younger ready entry bypasses an older entry that is not ready.
- R8: Both stations can issue in the same cycle.
- R9: A branch may issue while an older condition-logic entry is still waiting.
- R10: A wakeup (`wake_valid`, `wake_id`) sets the ready bit of every stored operand whose source id matches. It does the same for the instruction being dispatched in that cycle. The new ready bit takes effect from the next cycle.
- R11: `flush` refuses dispatch in its cycle and empties both stations. No issue follows until new dispatches arrive.
- R12: After reset both stations are empty, nothing issues, and dispatch is admitted.
- R13: While a unit-ready input is low, that station issues nothing and keeps its entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty both stations, refuse dispatch this cycle |
| disp_valid | input | 1 | An instruction is offered on the dispatch bus |
| disp_is_cr | input | 1 | 1 = condition-logic instruction, 0 = branch |
| disp_tag | input | TAG_W (6) | Tag of the offered instruction |
| disp_src | input | NSRC*SRC_W (10) | Source ids; operand k in bits [k*SRC_W +: SRC_W] |
| disp_src_rdy | input | NSRC (2) | Ready bit per operand at dispatch |
| wake_valid | input | 1 | A result is broadcast this cycle |
| wake_id | input | SRC_W (5) | Source id of the broadcast result |
| br_unit_ready | input | 1 | Branch unit can take an instruction |
| cr_unit_ready | input | 1 | Condition-logic unit can take an instruction |
| disp_accept | output | 1 | Offered instruction is admitted this cycle |
| br_issue_valid | output | 1 | Branch station issues this cycle |
| br_issue_tag | output | TAG_W (6) | Tag of the issuing branch |
| cr_issue_valid | output | 1 | Condition-logic station issues this cycle |
| cr_issue_tag | output | TAG_W (6) | Tag of the issuing condition-logic entry |

## Verification
The hardest state to reach from the ports is the one behind R3. In it, one station is full, its oldest entry issues, and another instruction is offered in the same cycle. To get there, the stimulus parks an older branch that is not ready behind a younger ready one. It then wakes the older branch and offers a condition-logic instruction in the cycle that branch issues. The condition-logic bypass of R7 needs a similar setup. A not-ready entry is pinned at the head with a ready entry behind it, and the CR unit is stalled for a cycle so that both entries are present together.

// File: rtl/dgate_pkg.sv
// Package: shared sizes and the reservation-station entry type of the
// branch / condition-logic dispatch gate.
package dgate_pkg;
    localparam int TAG_W    = 6;
    localparam int SRC_W    = 5;
    localparam int NSRC     = 2;
    localparam int RS_DEPTH = 2;

    typedef struct packed {
        logic [TAG_W-1:0]            tag;
        logic [NSRC-1:0][SRC_W-1:0]  src;
        logic [NSRC-1:0]             rdy;
    } rs_entry_t;
endpackage

// File: rtl/rs_pick.sv
// Module: rs_pick
// Chooses which station slot issues. Slot 0 is the oldest entry.
// IN_ORDER=1 grants only slot 0. IN_ORDER=0 grants the lowest-numbered
// requesting slot, which is the oldest ready entry.
// Assumes the requests come from valid, age-ordered slots.
module rs_pick #(
    parameter int DEPTH    = 2,
    parameter bit IN_ORDER = 1'b0,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);
    generate
        if (IN_ORDER) begin : g_head
            // Only the head entry may leave.
            assign gnt_vld = req[0];
            assign gnt_idx = '0;
        end else begin : g_oldest
            // Scan from youngest to oldest so the oldest ready entry wins.
            always_comb begin
                gnt_idx = '0;
                for (int i = DEPTH - 1; i >= 0; i--) begin
                    if (req[i]) gnt_idx = IDX_W'(i);
                end
            end
            assign gnt_vld = |req;
        end
    endgenerate
endmodule

// File: rtl/rs_station.sv
// Module: rs_station
// Small age-ordered reservation station. Valid entries sit in the lowest
// slots, and slot 0 is the oldest. It takes at most one push and one issue
// per cycle. An issue compacts the younger entries downward. Wakeups set
// operand ready bits from the next cycle on.
// Assumes push is never raised while full is high, which the gate ensures.
module rs_station
    import dgate_pkg::*;
#(
    parameter int DEPTH    = 2,
    parameter bit IN_ORDER = 1'b0,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  rs_entry_t        push_entry,
    input  logic             wake_valid,
    input  logic [SRC_W-1:0] wake_id,
    input  logic             unit_ready,
    output logic             full,
    output logic             issue_valid,
    output logic [TAG_W-1:0] issue_tag
);
    rs_entry_t          ent_q [DEPTH];
    rs_entry_t          ent_n [DEPTH];
    logic [DEPTH-1:0]   vld_q, vld_n;
    logic [DEPTH-1:0]   ready_vec;
    logic               gnt_vld;
    logic [IDX_W-1:0]   gnt_idx;
    logic               fire;
    int                 occ;

    // Return an entry with the broadcast wakeup applied to its ready bits.
    function automatic rs_entry_t apply_wake(input rs_entry_t e);
        rs_entry_t r;
        r = e;
        for (int k = 0; k < NSRC; k++) begin
            if (wake_valid && (e.src[k] == wake_id)) r.rdy[k] = 1'b1;
        end
        return r;
    endfunction

    // Flag the slots whose operands are all ready.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) ready_vec[i] = vld_q[i] & (&ent_q[i].rdy);
    end

    rs_pick #(.DEPTH(DEPTH), .IN_ORDER(IN_ORDER)) u_pick (
        .req     (ready_vec),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    assign fire        = gnt_vld & unit_ready;
    assign issue_valid = fire;
    assign issue_tag   = ent_q[gnt_idx].tag;
    assign full        = vld_q[DEPTH-1];

    // Count the occupied slots.
    always_comb begin
        occ = 0;
        for (int i = 0; i < DEPTH; i++) occ += int'(vld_q[i]);
    end

    // Next state: remove the issued slot, compact, wake, then append the push.
    always_comb begin
        int slot;
        vld_n = '0;
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = (fire && (i >= int'(gnt_idx))) ? i + 1 : i;
            if (s < DEPTH) begin
                vld_n[i] = vld_q[IDX_W'(s)];
                ent_n[i] = apply_wake(ent_q[IDX_W'(s)]);
            end
        end
        slot = occ - (fire ? 1 : 0);
        if (push && (slot < DEPTH)) begin
            vld_n[IDX_W'(slot)] = 1'b1;
            ent_n[IDX_W'(slot)] = apply_wake(push_entry);
        end
    end

    // Slot valid bits: cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) vld_q <= '0;
        else                 vld_q <= vld_n;
    end

    // Slot payloads: qualified by the valid bits, so no reset is needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
    end
endmodule

// File: rtl/dispatch_gate.sv
// Module: dispatch_gate (top)
// One dispatch bus feeds two reservation stations: a branch station, which
// issues in age order, and a condition-logic station, which issues its
// oldest ready entry. Dispatch stops for both while either station is full.
// The full flags are registered, so a slot freed this cycle counts next cycle.
// Assumes the upstream holds an offered instruction until disp_accept.
module dispatch_gate
    import dgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  disp_valid,
    input  logic                  disp_is_cr,
    input  logic [TAG_W-1:0]      disp_tag,
    input  logic [NSRC*SRC_W-1:0] disp_src,
    input  logic [NSRC-1:0]       disp_src_rdy,
    input  logic                  wake_valid,
    input  logic [SRC_W-1:0]      wake_id,
    input  logic                  br_unit_ready,
    input  logic                  cr_unit_ready,
    output logic                  disp_accept,
    output logic                  br_issue_valid,
    output logic [TAG_W-1:0]      br_issue_tag,
    output logic                  cr_issue_valid,
    output logic [TAG_W-1:0]      cr_issue_tag
);
    localparam int NUNIT = 2;   // index 0: branch, index 1: condition logic

    rs_entry_t        new_entry;
    logic [NUNIT-1:0] unit_full, unit_push, unit_rdy, unit_iv;
    logic [TAG_W-1:0] unit_tag [NUNIT];

    // Pack the offered instruction into a station entry.
    always_comb begin
        new_entry.tag = disp_tag;
        new_entry.rdy = disp_src_rdy;
        for (int k = 0; k < NSRC; k++) new_entry.src[k] = disp_src[k*SRC_W +: SRC_W];
    end

    // Shared-bus admission: a full station blocks both kinds.
    assign disp_accept  = disp_valid & ~flush & ~(|unit_full);
    assign unit_push[0] = disp_accept & ~disp_is_cr;
    assign unit_push[1] = disp_accept &  disp_is_cr;
    assign unit_rdy     = {cr_unit_ready, br_unit_ready};

    generate
        for (genvar u = 0; u < NUNIT; u++) begin : g_unit
            rs_station #(.DEPTH(RS_DEPTH), .IN_ORDER(u == 0)) u_rs (
                .clk         (clk),
                .rst_n       (rst_n),
                .flush       (flush),
                .push        (unit_push[u]),
                .push_entry  (new_entry),
                .wake_valid  (wake_valid),
                .wake_id     (wake_id),
                .unit_ready  (unit_rdy[u]),
                .full        (unit_full[u]),
                .issue_valid (unit_iv[u]),
                .issue_tag   (unit_tag[u])
            );
        end
    endgenerate

    assign br_issue_valid = unit_iv[0];
    assign br_issue_tag   = unit_tag[0];
    assign cr_issue_valid = unit_iv[1];
    assign cr_issue_tag   = unit_tag[1];
endmodule

// File: rtl/dispatch_gate_chk.sv
// Module: dispatch_gate_chk
// Port-level checker for dispatch_gate. It keeps its own occupancy count per
// station from the accepted dispatches and the issues, and checks the
// admission and issue rules against that count.
module dispatch_gate_chk
    import dgate_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  disp_valid,
    input logic                  disp_is_cr,
    input logic                  disp_accept,
    input logic                  br_unit_ready,
    input logic                  cr_unit_ready,
    input logic                  br_issue_valid,
    input logic                  cr_issue_valid
);
    int cnt_br, cnt_cr;

    // Shadow occupancy derived only from port activity.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_br <= 0;
            cnt_cr <= 0;
        end else begin
            cnt_br <= cnt_br + int'(disp_accept & ~disp_is_cr) - int'(br_issue_valid);
            cnt_cr <= cnt_cr + int'(disp_accept &  disp_is_cr) - int'(cr_issue_valid);
        end
    end

    a_r4_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_br <= DEPTH) && (cnt_cr <= DEPTH));
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_br == DEPTH) || (cnt_cr == DEPTH)) |-> !disp_accept);
    a_r2_room_admits: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !flush && (cnt_br < DEPTH) && (cnt_cr < DEPTH)) |-> disp_accept);
    a_r1_accept_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        disp_accept |-> disp_valid);
    a_r5_br_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        br_issue_valid |-> (cnt_br > 0));
    a_r5_cr_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        cr_issue_valid |-> (cnt_cr > 0));
    a_r13_br_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        br_issue_valid |-> br_unit_ready);
    a_r13_cr_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cr_issue_valid |-> cr_unit_ready);
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!br_issue_valid && !cr_issue_valid));
endmodule

bind dispatch_gate dispatch_gate_chk #(.DEPTH(dgate_pkg::RS_DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .disp_valid     (disp_valid),
    .disp_is_cr     (disp_is_cr),
    .disp_accept    (disp_accept),
    .br_unit_ready  (br_unit_ready),
    .cr_unit_ready  (cr_unit_ready),
    .br_issue_valid (br_issue_valid),
    .cr_issue_valid (cr_issue_valid)
);

// File: tb/dispatch_gate_bench.sv
// Bench for dispatch_gate. A vector table first, then directed tests.
// Inputs change at the falling edge. Outputs are compared 1 time unit later.
module dispatch_gate_bench;
    import dgate_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                  clk = 1'b0;
    logic                  rst_n, flush, disp_valid, disp_is_cr;
    logic [TAG_W-1:0]      disp_tag;
    logic [NSRC*SRC_W-1:0] disp_src;
    logic [NSRC-1:0]       disp_src_rdy;
    logic                  wake_valid;
    logic [SRC_W-1:0]      wake_id;
    logic                  br_unit_ready, cr_unit_ready;
    logic                  disp_accept, br_issue_valid, cr_issue_valid;
    logic [TAG_W-1:0]      br_issue_tag, cr_issue_tag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispatch_gate u_dispatch_gate (
        .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
        .disp_is_cr(disp_is_cr), .disp_tag(disp_tag), .disp_src(disp_src),
        .disp_src_rdy(disp_src_rdy), .wake_valid(wake_valid), .wake_id(wake_id),
        .br_unit_ready(br_unit_ready), .cr_unit_ready(cr_unit_ready),
        .disp_accept(disp_accept), .br_issue_valid(br_issue_valid),
        .br_issue_tag(br_issue_tag), .cr_issue_valid(cr_issue_valid),
        .cr_issue_tag(cr_issue_tag)
    );

    typedef struct packed {
        logic       fl;   logic dv;  logic cr;  logic [5:0] tag; logic [4:0] sid;
        logic [1:0] srdy; logic wv;  logic [4:0] wid; logic bru;  logic cru;
        logic       ea;   logic ebv; logic [5:0] ebt; logic ecv;  logic [5:0] ect;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    //  fl dv cr tag sid srdy wv wid bru cru | ea ebv ebt ecv ect | req
    localparam vec_t TBL [NV] = '{
        '{0,1,0, 1, 1,3,0, 0,1,1, 1,0, 0,0,0,  1},  // R1 branch admitted
        '{0,1,0, 2, 2,0,0, 0,1,1, 1,1, 1,0,0,  5},  // R5 issue cycle after dispatch
        '{0,1,0, 3, 3,3,0, 0,1,1, 1,0, 0,0,0,  6},  // R6 head not ready, nothing leaves
        '{0,1,1, 4, 4,3,0, 0,1,1, 0,0, 0,0,0,  2},  // R2 full branch RS blocks CR
        '{0,0,0, 0, 0,0,1, 2,1,1, 0,0, 0,0,0, 10},  // R10 wake seen next cycle
        '{0,1,1, 4, 4,3,0, 0,1,1, 0,1, 2,0,0,  3},  // R3 freed slot not reused now
        '{0,1,1, 4, 4,3,0, 0,1,1, 1,1, 3,0,0,  1},  // R1 CR admitted, younger branch out
        '{0,1,1, 5, 5,0,0, 0,1,0, 1,0, 0,0,0, 13},  // R13 CR unit busy holds entry
        '{0,1,0, 6, 6,3,0, 0,1,1, 0,0, 0,1,4,  2},  // R2 full CR RS blocks branch
        '{0,1,1, 7, 7,3,0, 0,1,1, 1,0, 0,0,0,  7},  // R7 head not ready
        '{0,0,0, 0, 0,0,0, 0,1,1, 0,0, 0,1,7,  7},  // R7 younger ready bypasses
        '{0,1,0, 8, 8,3,1, 5,1,1, 1,0, 0,0,0, 10},  // R10 wake stored CR operand
        '{0,0,0, 0, 0,0,0, 0,1,1, 0,1, 8,1,5,  8},  // R8 both issue together
        '{0,1,1, 9, 9,0,0, 0,1,1, 1,0, 0,0,0,  1},  // R1 CR not ready
        '{0,1,0,10,10,3,0, 0,1,1, 1,0, 0,0,0,  1},  // R1 younger branch
        '{0,0,0, 0, 0,0,0, 0,1,1, 0,1,10,0,0,  9},  // R9 branch passes older CR
        '{0,1,0,11,12,0,1,12,1,1, 1,0, 0,0,0, 10},  // R10 wake during dispatch
        '{0,0,0, 0, 0,0,0, 0,1,1, 0,1,11,0,0, 10},  // R10 woken at dispatch issues
        '{0,1,0,12,12,3,0, 0,1,1, 1,0, 0,0,0,  1},  // R1 branch before flush
        '{1,1,0,13,13,3,0, 0,0,1, 0,0, 0,0,0, 11},  // R11 flush refuses dispatch
        '{0,0,0, 0, 0,0,1, 9,1,1, 0,0, 0,0,0, 11},  // R11 emptied, wake finds nothing
        '{0,0,0, 0, 0,0,0, 0,1,1, 0,0, 0,0,0, 11}   // R11 still empty
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
            13: return "R13";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic fl, input logic dv, input logic cr, input int tag,
                         input int sid, input int srdy, input logic wv, input int wid,
                         input logic bru, input logic cru);
        flush        = fl;
        disp_valid   = dv;
        disp_is_cr   = cr;
        disp_tag     = TAG_W'(tag);
        disp_src     = {SRC_W'(sid), SRC_W'(sid)};
        disp_src_rdy = NSRC'(srdy);
        wake_valid   = wv;
        wake_id      = SRC_W'(wid);
        br_unit_ready = bru;
        cr_unit_ready = cru;
    endtask

    task automatic check_outs(input string req, input logic ea, input logic ebv, input int ebt,
                              input logic ecv, input int ect);
        check(req, "disp_accept", int'(disp_accept), int'(ea));
        check(req, "br_issue_valid", int'(br_issue_valid), int'(ebv));
        if (ebv) check(req, "br_issue_tag", int'(br_issue_tag), ebt);
        check(req, "cr_issue_valid", int'(cr_issue_valid), int'(ecv));
        if (ecv) check(req, "cr_issue_tag", int'(cr_issue_tag), ect);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state, nothing issues and nothing is offered.
        #1 check_outs("R12", 0, 0, 0, 0, 0);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(TBL[v].fl, TBL[v].dv, TBL[v].cr, int'(TBL[v].tag), int'(TBL[v].sid),
                  int'(TBL[v].srdy), TBL[v].wv, int'(TBL[v].wid), TBL[v].bru, TBL[v].cru);
            #1 check_outs(rname(int'(TBL[v].req)), TBL[v].ea, TBL[v].ebv, int'(TBL[v].ebt),
                          TBL[v].ecv, int'(TBL[v].ect));
        end

        // R4: two waiting branches fill the station, a third is refused.
        @(negedge clk); drive(0, 1, 0, 20, 20, 0, 0, 0, 1, 1);
        #1 check("R4", "accept first", int'(disp_accept), 1);
        @(negedge clk); drive(0, 1, 0, 21, 21, 0, 0, 0, 1, 1);
        #1 check("R4", "accept second", int'(disp_accept), 1);
        @(negedge clk); drive(0, 1, 0, 22, 22, 3, 0, 0, 1, 1);
        #1 check("R4", "accept third", int'(disp_accept), 0);
        @(negedge clk); drive(1, 0, 0, 0, 0, 0, 0, 0, 1, 1);

        // R12: fill the CR station, reset mid-run, then confirm it is empty.
        @(negedge clk); drive(0, 1, 1, 23, 23, 3, 0, 0, 1, 0);
        #1 check("R12", "accept pre-reset", int'(disp_accept), 1);
        @(negedge clk); drive(0, 1, 1, 24, 24, 3, 0, 0, 1, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(0, 1, 0, 25, 25, 3, 0, 0, 1, 1);
        #1 check_outs("R12", 1, 0, 0, 0, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        #1 check_outs("R12", 0, 1, 25, 0, 0);

        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule